// File: doc/BRIEF.md
# DDR Request Packer

This block turns client memory requests into the pushes a DDR SDRAM controller expects on its user side. A client names a bank, row and column and says whether it wants a read or a write. The block folds these into the controller's 31-bit address word and forces the column onto a burst boundary. It then pushes one command into the controller's command FIFO.

For a write, the client also hands over the burst one beat at a time. Each beat is as wide as the external DDR data bus and comes with active-high byte enables. The block pairs consecutive beats into double-width user words and turns the enables into an active-high write mask. It pushes burst_length/2 such words into the write-data FIFO before it releases the write command. Both FIFOs give almost-full back, and the block stalls the client on either of them.

Top module: `ddr_req_packer`

## Requirements
- R1: The command address `af_addr` is 31 bits. The column sits in bits [COL_W-1:0], the row directly above it, the bank above the row, and every bit above the bank is zero.
- R2: The lowest log2(BURST_LEN) column bits are forced to zero in `af_addr`. `align_err` is high for exactly the one cycle after the accepted request whose column had any of those bits set, and low otherwise.
- R3: `af_cmd` carries 3'b000 for a write and 3'b001 for a read.
- R4: Every write command is preceded by exactly BURST_LEN/2 pushes on `wdf_data`. Each word holds the earlier beat of a pair in bits [DQ_W-1:0] and the later beat in bits [2*DQ_W-1:DQ_W]. Words follow beat order.
- R5: No write-data push of a burst happens after the push of its command, and the command push follows its last data push by at least one cycle.
- R6: With masking enabled, mask bit i covers byte i of the pushed word and equals the inverse of that byte's enable, so all enables high give an all-zero mask.
- R7: With MASK_EN = 0, `wdf_mask` is all zeros on every data push, whatever the enables.
- R8: `cmd_ready` and `dat_ready` are low in every cycle in which `af_afull` or `wdf_afull` is high. `af_wr_en` is never high with `af_afull`, and `wdf_wr_en` is never high with `wdf_afull`.
- R9: While a command or data word waits behind almost-full, its address, code, data and mask stay unchanged until the push.
- R10: A read gives exactly one command push and no data push.
- R11: After reset, no push is pending, `align_err` is low, `dat_ready` is low and `cmd_ready` is high when neither FIFO is almost-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Client request present |
| cmd_ready | output | 1 | Request accepted on this edge when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | BANK_W | Bank |
| cmd_row | input | ROW_W | Row |
| cmd_col | input | COL_W | Column |
| dat_valid | input | 1 | Write beat present |
| dat_ready | output | 1 | Beat accepted on this edge when valid |
| dat_beat | input | DQ_W | Write beat at external data width |
| dat_be | input | DQ_W/8 | Active-high byte enables of the beat |
| align_err | output | 1 | One-cycle flag for a misaligned column |
| af_afull | input | 1 | Command FIFO almost full |
| af_wr_en | output | 1 | Command FIFO push |
| af_cmd | output | 3 | Command code |
| af_addr | output | 31 | Packed address |
| wdf_afull | input | 1 | Write-data FIFO almost full |
| wdf_wr_en | output | 1 | Write-data FIFO push |
| wdf_data | output | 2*DQ_W | Double-width write word |
| wdf_mask | output | DQ_W/4 | Active-high byte mask |

## Verification
The bench sends a read and several writes, with addresses at the field maxima and in the middle, and with enable patterns that are all high, mixed and all low. These show whether fields land at the right offsets, whether beats pair in the right order and whether mask bits are inverted and placed correctly. A column with non-zero low bits separates forced alignment and its flag from normal requests. Almost-full is raised on each FIFO, both before a request and while a push is pending, to show whether the block stalls and holds its outputs. A second instance with masking off receives the same stimulus, so the two mask variants can be compared.

// File: rtl/ddr_pack_pkg.sv
// Shared constants and types for the DDR request packer.
// Assumes: the controller address word is fixed at 31 bits.
package ddr_pack_pkg;
    localparam int CTRL_ADDR_W = 31;

    typedef enum logic [2:0] {
        CMD_WRITE = 3'b000,
        CMD_READ  = 3'b001
    } cmd_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CMD  = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/ddr_addr_pack.sv
// Folds bank/row/column into the controller address word and aligns the column.
// Assumes COL_W+ROW_W+BANK_W <= 31 and COL_W >= log2(BURST_LEN); purely combinational.
module ddr_addr_pack
    import ddr_pack_pkg::*;
#(
    parameter int COL_W     = 10,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 3,
    parameter int BURST_LEN = 4
) (
    input  logic [BANK_W-1:0]      bank,
    input  logic [ROW_W-1:0]       row,
    input  logic [COL_W-1:0]       col,
    output logic [CTRL_ADDR_W-1:0] addr,
    output logic                   misaligned
);
    localparam int ALIGN_B = $clog2(BURST_LEN);

    logic [COL_W-1:0] col_al;

    // Clear the in-burst column bits and note whether any were set.
    always_comb begin
        col_al     = col;
        col_al[ALIGN_B-1:0] = '0;
        misaligned = |col[ALIGN_B-1:0];
    end

    // Column lowest, row above, bank on top, unused bits zero.
    always_comb begin
        addr = '0;
        addr[COL_W-1:0]              = col_al;
        addr[COL_W +: ROW_W]         = row;
        addr[COL_W+ROW_W +: BANK_W]  = bank;
    end
endmodule

// File: rtl/ddr_beat_packer.sv
// Collects BURST_LEN write beats, pairs them into double-width words with
// active-high masks, and pushes each word into the write-data FIFO.
// Assumes start is pulsed only while idle; the first beat of a pair is the low half.
module ddr_beat_packer #(
    parameter int DQ_W      = 16,
    parameter int BURST_LEN = 4,
    parameter bit MASK_EN   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  hold,
    input  logic                  dat_valid,
    input  logic [DQ_W-1:0]       dat_beat,
    input  logic [DQ_W/8-1:0]     dat_be,
    output logic                  dat_ready,
    input  logic                  wdf_afull,
    output logic                  wdf_wr_en,
    output logic [2*DQ_W-1:0]     wdf_data,
    output logic [DQ_W/4-1:0]     wdf_mask,
    output logic                  burst_done
);
    localparam int BE_W  = DQ_W / 8;
    localparam int UW    = 2 * DQ_W;
    localparam int MW    = 2 * BE_W;
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    logic              active_q;
    logic [CNT_W-1:0]  left_q;
    logic              half_q;
    logic [DQ_W-1:0]   lo_beat_q;
    logic              pend_q;
    logic [UW-1:0]     data_q;
    logic              beat_acc;

    // Beats flow only inside a burst and while neither FIFO is almost full.
    assign dat_ready  = active_q & (left_q != '0) & ~hold & ~wdf_afull;
    assign beat_acc   = dat_valid & dat_ready;
    assign wdf_wr_en  = pend_q & ~wdf_afull;
    assign burst_done = wdf_wr_en & active_q & (left_q == '0);
    assign wdf_data   = data_q;

    // Burst bookkeeping, beat pairing and pending-word tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            left_q    <= '0;
            half_q    <= 1'b0;
            lo_beat_q <= '0;
            pend_q    <= 1'b0;
            data_q    <= '0;
        end else begin
            if (start) begin
                active_q <= 1'b1;
                left_q   <= CNT_W'(BURST_LEN);
                half_q   <= 1'b0;
            end
            if (burst_done) active_q <= 1'b0;
            if (wdf_wr_en)  pend_q   <= 1'b0;
            if (beat_acc) begin
                left_q <= left_q - 1'b1;
                if (!half_q) begin
                    lo_beat_q <= dat_beat;
                    half_q    <= 1'b1;
                end else begin
                    data_q <= {dat_beat, lo_beat_q};
                    pend_q <= 1'b1;
                    half_q <= 1'b0;
                end
            end
        end
    end

    generate
        if (MASK_EN) begin : g_mask
            logic [BE_W-1:0] lo_be_q;
            logic [MW-1:0]   mask_q;

            // Invert enables into the mask, pairing them like the data.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_be_q <= '0;
                    mask_q  <= '0;
                end else if (beat_acc) begin
                    if (!half_q) lo_be_q <= dat_be;
                    else         mask_q  <= ~{dat_be, lo_be_q};
                end
            end
            assign wdf_mask = mask_q;
        end else begin : g_nomask
            assign wdf_mask = '0;

            p_mask_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
                wdf_wr_en |-> (wdf_mask == '0));
        end
    endgenerate

    // A word stalled by almost-full keeps its contents until pushed.
    p_word_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && wdf_afull) |=> (pend_q && $stable(wdf_data) && $stable(wdf_mask)));

    // No data push into an almost-full FIFO, and no beat taken then.
    p_wdf_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdf_afull |-> (!wdf_wr_en && !dat_ready));
endmodule

// File: rtl/ddr_req_packer.sv
// Top: accepts client read/write requests, packs the address, drives the
// command and write-data FIFO pushes, and orders all data before its command.
// Assumes both FIFOs accept a push whenever their almost-full is low.
module ddr_req_packer
    import ddr_pack_pkg::*;
#(
    parameter int DQ_W      = 16,
    parameter int COL_W     = 10,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 3,
    parameter int BURST_LEN = 4,
    parameter bit MASK_EN   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic                  cmd_write,
    input  logic [BANK_W-1:0]     cmd_bank,
    input  logic [ROW_W-1:0]      cmd_row,
    input  logic [COL_W-1:0]      cmd_col,
    input  logic                  dat_valid,
    output logic                  dat_ready,
    input  logic [DQ_W-1:0]       dat_beat,
    input  logic [DQ_W/8-1:0]     dat_be,
    output logic                  align_err,
    input  logic                  af_afull,
    output logic                  af_wr_en,
    output logic [2:0]            af_cmd,
    output logic [30:0]           af_addr,
    input  logic                  wdf_afull,
    output logic                  wdf_wr_en,
    output logic [2*DQ_W-1:0]     wdf_data,
    output logic [DQ_W/4-1:0]     wdf_mask
);
    localparam int USED_W  = COL_W + ROW_W + BANK_W;
    localparam int ALIGN_B = $clog2(BURST_LEN);
    localparam int WPB     = BURST_LEN / 2;
    localparam int WCNT_W  = $clog2(WPB + 1) + 1;

    generate
        if (USED_W > CTRL_ADDR_W) begin : g_bad_width
            $error("column+row+bank width exceeds the 31-bit address word");
        end
        if (BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_burst
            $error("burst length must be 4 or 8");
        end
    endgenerate

    ctl_state_e            state_q;
    cmd_code_e             code_q;
    logic [CTRL_ADDR_W-1:0] addr_q;
    logic [CTRL_ADDR_W-1:0] addr_packed;
    logic                  misaligned;
    logic                  cmd_acc;
    logic                  burst_done;

    ddr_addr_pack #(
        .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN)
    ) u_addr (
        .bank(cmd_bank), .row(cmd_row), .col(cmd_col),
        .addr(addr_packed), .misaligned(misaligned)
    );

    ddr_beat_packer #(
        .DQ_W(DQ_W), .BURST_LEN(BURST_LEN), .MASK_EN(MASK_EN)
    ) u_beats (
        .clk(clk), .rst_n(rst_n),
        .start(cmd_acc & cmd_write), .hold(af_afull),
        .dat_valid(dat_valid), .dat_beat(dat_beat), .dat_be(dat_be),
        .dat_ready(dat_ready),
        .wdf_afull(wdf_afull), .wdf_wr_en(wdf_wr_en),
        .wdf_data(wdf_data), .wdf_mask(wdf_mask),
        .burst_done(burst_done)
    );

    // New requests only when idle and both FIFOs have room.
    assign cmd_ready = (state_q == ST_IDLE) & ~af_afull & ~wdf_afull;
    assign cmd_acc   = cmd_valid & cmd_ready;
    assign af_wr_en  = (state_q == ST_CMD) & ~af_afull;
    assign af_cmd    = code_q;
    assign af_addr   = addr_q;

    // Request sequencing: capture, wait for the burst's data, push the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            code_q    <= CMD_READ;
            addr_q    <= '0;
            align_err <= 1'b0;
        end else begin
            align_err <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (cmd_acc) begin
                    addr_q    <= addr_packed;
                    code_q    <= cmd_write ? CMD_WRITE : CMD_READ;
                    align_err <= misaligned;
                    state_q   <= cmd_write ? ST_DATA : ST_CMD;
                end
                ST_DATA: if (burst_done) state_q <= ST_CMD;
                ST_CMD:  if (af_wr_en)   state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker bookkeeping: data words pushed since the last command push.
    logic [WCNT_W-1:0] wcnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         wcnt_q <= '0;
        else if (af_wr_en)  wcnt_q <= '0;
        else if (wdf_wr_en) wcnt_q <= wcnt_q + 1'b1;
    end

    p_write_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (af_wr_en && af_cmd == CMD_WRITE) |-> (wcnt_q == WCNT_W'(WPB)));

    p_read_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (af_wr_en && af_cmd == CMD_READ) |-> (wcnt_q == '0));

    p_data_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdf_wr_en |-> (!af_wr_en && wcnt_q < WCNT_W'(WPB)));

    p_col_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        af_wr_en |-> (af_addr[ALIGN_B-1:0] == '0));

    p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        af_wr_en |-> (af_cmd == CMD_WRITE || af_cmd == CMD_READ));

    p_cmd_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && !af_wr_en) |=>
            (af_wr_en || state_q == ST_CMD) && $stable(af_addr) && $stable(af_cmd));

    p_ready_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (af_afull || wdf_afull) |-> (!cmd_ready && !dat_ready && !af_wr_en || !af_afull && !cmd_ready && !dat_ready));

    generate
        if (USED_W < CTRL_ADDR_W) begin : g_upper_chk
            p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
                af_wr_en |-> (af_addr[CTRL_ADDR_W-1:USED_W] == '0));
        end
    endgenerate
endmodule

// File: tb/tb_ddr_req_packer.sv
// Scoreboard bench: driver tasks queue expected pushes, a negedge monitor
// pops and compares them as the two instances push.
module tb_ddr_req_packer;
    localparam int DQ_W = 16, COL_W = 10, ROW_W = 13, BANK_W = 3, BL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              cmd_valid = 0, cmd_write = 0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [ROW_W-1:0]  cmd_row = '0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic              dat_valid = 0;
    logic [DQ_W-1:0]   dat_beat = '0;
    logic [1:0]        dat_be = '0;
    logic              af_afull = 0, wdf_afull = 0;

    logic cmd_ready, dat_ready, align_err, af_wr_en, wdf_wr_en;
    logic [2:0] af_cmd;  logic [30:0] af_addr;
    logic [31:0] wdf_data; logic [3:0] wdf_mask;

    logic n_cmd_ready, n_dat_ready, n_align_err, n_af_wr_en, n_wdf_wr_en;
    logic [2:0] n_af_cmd; logic [30:0] n_af_addr;
    logic [31:0] n_wdf_data; logic [3:0] n_wdf_mask;

    ddr_req_packer #(.DQ_W(DQ_W), .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W),
                     .BURST_LEN(BL), .MASK_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_beat(dat_beat), .dat_be(dat_be),
        .align_err(align_err), .af_afull(af_afull), .af_wr_en(af_wr_en), .af_cmd(af_cmd),
        .af_addr(af_addr), .wdf_afull(wdf_afull), .wdf_wr_en(wdf_wr_en),
        .wdf_data(wdf_data), .wdf_mask(wdf_mask));

    ddr_req_packer #(.DQ_W(DQ_W), .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W),
                     .BURST_LEN(BL), .MASK_EN(1'b0)) dut_nomask (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(n_cmd_ready),
        .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .dat_valid(dat_valid), .dat_ready(n_dat_ready), .dat_beat(dat_beat), .dat_be(dat_be),
        .align_err(n_align_err), .af_afull(af_afull), .af_wr_en(n_af_wr_en), .af_cmd(n_af_cmd),
        .af_addr(n_af_addr), .wdf_afull(wdf_afull), .wdf_wr_en(n_wdf_wr_en),
        .wdf_data(n_wdf_data), .wdf_mask(n_wdf_mask));

    int checks = 0, errors = 0;
    logic [30:0] eq_addr[$];
    logic [2:0]  eq_cmd[$];
    logic [31:0] eq_data[$];
    logic [3:0]  eq_mask[$];
    int wcnt = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // R1: bank at bit 23, row at bit 10, column at bit 0; R2: low 2 column bits cleared.
    function automatic logic [30:0] pack(input int b, input int r, input int c);
        return 31'((b << 23) | (r << 10) | (c & ~3));
    endfunction

    task automatic send_cmd(input bit wr, input int b, input int r, input int c);
        cmd_write = wr; cmd_bank = BANK_W'(b); cmd_row = ROW_W'(r); cmd_col = COL_W'(c);
        cmd_valid = 1'b1;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic send_beat(input logic [15:0] d, input logic [1:0] e);
        dat_beat = d; dat_be = e; dat_valid = 1'b1;
        do @(negedge clk); while (!dat_ready);
        @(posedge clk); #1;
        dat_valid = 1'b0;
    endtask

    // Queue a write's expectations: R4 word = {later, earlier}, R6 mask = ~enables, R3 code 000.
    task automatic exp_write(input int b, input int r, input int c,
                             input logic [15:0] d0, d1, d2, d3, input logic [1:0] e0, e1, e2, e3);
        eq_data.push_back({d1, d0}); eq_mask.push_back(~{e1, e0});
        eq_data.push_back({d3, d2}); eq_mask.push_back(~{e3, e2});
        eq_addr.push_back(pack(b, r, c)); eq_cmd.push_back(3'b000);
    endtask

    task automatic do_write(input int b, input int r, input int c,
                            input logic [15:0] d0, d1, d2, d3, input logic [1:0] e0, e1, e2, e3);
        exp_write(b, r, c, d0, d1, d2, d3, e0, e1, e2, e3);
        send_cmd(1'b1, b, r, c);
        send_beat(d0, e0); send_beat(d1, e1); send_beat(d2, e2); send_beat(d3, e3);
    endtask

    task automatic do_read(input int b, input int r, input int c);
        eq_addr.push_back(pack(b, r, c)); eq_cmd.push_back(3'b001);  // R3 read = 001
        send_cmd(1'b0, b, r, c);
    endtask

    // Monitor: compare pushes against the scoreboard away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (af_afull && af_wr_en)   chk(1'b0, "R8 cmd push under afull", 1, 0);
            if (wdf_afull && wdf_wr_en) chk(1'b0, "R8 data push under afull", 1, 0);
            if (wdf_wr_en) begin
                if (eq_data.size() == 0) chk(1'b0, "R10 unexpected data push", wdf_data, 0);
                else begin
                    logic [31:0] ed; logic [3:0] em;
                    ed = eq_data.pop_front(); em = eq_mask.pop_front();
                    chk(wdf_data == ed, "R4 data word", wdf_data, ed);
                    chk(wdf_mask == em, "R6 mask", wdf_mask, em);
                end
                chk(wcnt < 2, "R5 data after its command", wcnt, 1);
                wcnt++;
            end
            if (n_wdf_wr_en) chk(n_wdf_mask == 4'b0, "R7 mask with masking off", n_wdf_mask, 0);
            if (af_wr_en) begin
                if (eq_addr.size() == 0) chk(1'b0, "R3 unexpected command", af_addr, 0);
                else begin
                    logic [30:0] ea; logic [2:0] ec;
                    ea = eq_addr.pop_front(); ec = eq_cmd.pop_front();
                    chk(af_addr == ea, "R1 address", af_addr, ea);
                    chk(af_cmd == ec, "R3 code", af_cmd, ec);
                    if (ec == 3'b000) chk(wcnt == 2, "R4 words per write", wcnt, 2);
                    else              chk(wcnt == 0, "R10 read data", wcnt, 0);
                end
                wcnt = 0;
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog act=timeout exp=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R11 cmd_ready after reset", cmd_ready, 1);
        chk(!dat_ready && !af_wr_en && !wdf_wr_en && !align_err, "R11 idle outputs",
            {dat_ready, af_wr_en, wdf_wr_en, align_err}, 0);
        @(posedge clk); #1;

        do_read(2, 100, 8);                                       // R10
        do_write(5, 4000, 16, 16'hA001, 16'hA002, 16'hA003, 16'hA004,
                 2'b11, 2'b11, 2'b11, 2'b11);                     // R4, R6 all enabled
        do_write(1, 77, 40, 16'h1111, 16'h2222, 16'h3333, 16'h4444,
                 2'b01, 2'b10, 2'b00, 2'b11);                     // R6 mixed enables

        // R2: misaligned column 0x0F3 is forced to 0x0F0 and flagged for one cycle.
        exp_write(3, 9, 'h0F3, 16'hBEEF, 16'hCAFE, 16'h0F0F, 16'hF0F0,
                  2'b11, 2'b00, 2'b10, 2'b01);
        send_cmd(1'b1, 3, 9, 'h0F3);
        @(negedge clk);
        chk(align_err == 1'b1, "R2 align flag", align_err, 1);
        @(negedge clk);
        chk(align_err == 1'b0, "R2 align flag one cycle", align_err, 0);
        @(posedge clk); #1;
        send_beat(16'hBEEF, 2'b11); send_beat(16'hCAFE, 2'b00);
        send_beat(16'h0F0F, 2'b10); send_beat(16'hF0F0, 2'b01);

        do_read(7, 8191, 1023);                                   // R1 field maxima
        @(negedge clk);
        chk(align_err == 1'b1, "R2 align flag on read", align_err, 1);
        @(posedge clk); #1;

        // R8: no acceptance while the command FIFO is almost full.
        af_afull = 1'b1; cmd_write = 1'b0; cmd_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(cmd_ready == 1'b0, "R8 cmd_ready under af_afull", cmd_ready, 0);
        end
        @(posedge clk); #1;
        af_afull = 1'b0; cmd_valid = 1'b0;
        do_read(4, 1234, 260);

        // R9: command held behind almost-full keeps address and code.
        eq_addr.push_back(pack(6, 555, 100)); eq_cmd.push_back(3'b001);
        send_cmd(1'b0, 6, 555, 100);
        af_afull = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(af_addr == pack(6, 555, 100) && af_cmd == 3'b001, "R9 held command",
                af_addr, pack(6, 555, 100));
        end
        @(posedge clk); #1;
        af_afull = 1'b0;

        // R8/R9: write-data almost-full stalls beats and holds a finished word.
        exp_write(0, 42, 64, 16'h5A5A, 16'hA5A5, 16'h1234, 16'h5678,
                  2'b10, 2'b01, 2'b11, 2'b00);
        send_cmd(1'b1, 0, 42, 64);
        wdf_afull = 1'b1;
        dat_valid = 1'b1; dat_beat = 16'h5A5A; dat_be = 2'b10;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(dat_ready == 1'b0, "R8 dat_ready under wdf_afull", dat_ready, 0);
        end
        @(posedge clk); #1;
        dat_valid = 1'b0; wdf_afull = 1'b0;
        send_beat(16'h5A5A, 2'b10); send_beat(16'hA5A5, 2'b01);
        wdf_afull = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(wdf_data == 32'hA5A55A5A && wdf_mask == 4'b1001, "R9 held data word",
                wdf_data, 32'hA5A55A5A);
        end
        @(posedge clk); #1;
        wdf_afull = 1'b0;
        send_beat(16'h1234, 2'b11); send_beat(16'h5678, 2'b00);

        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(eq_addr.size() == 0, "R4 all commands pushed", eq_addr.size(), 0);
        chk(eq_data.size() == 0, "R5 all data pushed", eq_data.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule